// File: doc/BRIEF.md
# Software Trap Entry and Return Sequencer

This block is the multi-cycle engine that enters and leaves software traps. When a trap is requested it saves the status word and the return address on the system stack. It then reads the handler address from a vector table and hands a new program counter, status word and stack pointer back to the core. A return request does the reverse: it reads the saved program counter and status word from the stack held in the general stack register, and hands them back with that register moved past both words.

The sequencer captures the core's architectural values (PC, PS, system stack pointer, general stack register, table base) when it accepts a request. All stack and table traffic goes through one 32-bit memory port with a request/ready handshake. Results appear on the `new_*` outputs during the single cycle in which `commit` is high, and `busy` covers everything from acceptance to that cycle. The status word layout used here has C at bit 0, V at bit 1, Z at bit 2, N at bit 3, the interrupt-enable flag I at bit 4 and the stack-select flag S at bit 5.

States:
- `ST_IDLE` waits for a request.
- `ST_PUSH_PS` writes the status word.
- `ST_PUSH_PC` writes the return address.
- `ST_VEC_RD` reads the handler address.
- `ST_POP_PC` reads the saved PC.
- `ST_POP_PS` reads the saved status word.
- `ST_COMMIT` presents the results for one cycle.

Transitions:
- IDLE goes to PUSH_PS on a numbered or emulator trap, and to POP_PC on a return.
- PUSH_PS goes to PUSH_PC, PUSH_PC goes to VEC_RD, VEC_RD goes to COMMIT, POP_PC goes to POP_PS and POP_PS goes to COMMIT. Each of these moves only on a completed handshake.
- COMMIT always goes to IDLE.

Top module: `trap_seq`

## Requirements
- R1: After reset `busy`, `commit` and `mem_req` are all 0, and `mem_req` stays 0 whenever `busy` is 0.
- R2: A trap performs two writes in this order: the captured PS to address SSP-4, then the captured PC+2 to address SSP-8.
- R3: A numbered trap with 8-bit number n then reads the word at TBR+0x3FC-4*n and returns it as `new_pc`; n=0 reads TBR+0x3FC and n=255 reads TBR.
- R4: A numbered trap commits `new_ps` equal to the captured PS with bits 4 (I) and 5 (S) cleared and every other bit kept, `new_ssp` = SSP-8, and `new_gsp` equal to the captured general stack register.
- R5: An emulator trap performs the same two writes, reads the word at TBR+0x3D8 as `new_pc`, and clears only bit 5 (S), keeping bit 4 (I).
- R6: A return issues only reads. It reads `new_pc` from address G and `new_ps` (all bits, N/Z/V/C in bits 3:0 included) from G+4, where G is the general stack register. It commits `new_gsp` = G+8 and leaves `new_ssp` equal to the captured SSP.
- R7: Each memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is seen, and the sequence advances by one access per completed handshake. With w wait cycles per access, `busy` lasts 3(w+1)+1 cycles for a trap and 2(w+1)+1 cycles for a return.
- R8: `commit` is a one-cycle pulse in the last `busy` cycle, and requests arriving while `busy` is 1 are ignored.
- R9: When requests arrive together, a numbered trap wins over an emulator trap, which wins over a return.
- R10: A numbered trap followed by a return (with the general stack register set to the post-trap SSP) restores PS and the stack pointer to their pre-trap values and PC to the pre-trap PC+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_trap | input | 1 | Numbered trap request, sampled in idle |
| req_emu | input | 1 | Emulator trap request, sampled in idle |
| req_ret | input | 1 | Return request, sampled in idle |
| trap_num | input | 8 | Trap number for a numbered trap |
| arch_pc | input | 32 | Current PC of the trapping instruction |
| arch_ps | input | 32 | Current status word |
| arch_ssp | input | 32 | System stack pointer |
| arch_gsp | input | 32 | General stack register used by return |
| arch_tbr | input | 32 | Vector table base |
| busy | output | 1 | Sequence in progress |
| commit | output | 1 | Results valid this cycle |
| new_pc | output | 32 | Resulting PC |
| new_ps | output | 32 | Resulting status word |
| new_ssp | output | 32 | Resulting system stack pointer |
| new_gsp | output | 32 | Resulting general stack register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The bench covers the two ends of the vector table (trap numbers 0 and 255), where a design that scaled or signed the number wrongly would read outside the table or the wrong entry. It covers an emulator trap arriving with I set, which catches a design that clears I for both trap kinds. It also covers simultaneous requests and a return request injected mid-sequence, where a wrong priority or a leaky idle check would start the wrong sequence or a second one. Waits on the memory port and a full trap-then-return round trip catch a sequencer that advances without ready, swaps the push order, or moves the stack pointer by the wrong amount.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PS,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_POP_PC,
        ST_POP_PS,
        ST_COMMIT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_TRAP,
        OP_EMU,
        OP_RET
    } seq_op_t;

    localparam int PS_BIT_I = 4;
    localparam int PS_BIT_S = 5;

endpackage

// File: rtl/trap_seq_vec.sv
module trap_seq_vec #(
    parameter int DATA_W  = 32,
    parameter int NUM_W   = 8,
    parameter int VEC_TOP = 'h3FC,
    parameter int EMU_OFF = 'h3D8
) (
    input  logic [DATA_W-1:0] tbr,
    input  logic [NUM_W-1:0]  num,
    input  logic              is_emu,
    output logic [DATA_W-1:0] vec_addr
);
    logic [DATA_W-1:0] scaled;

    // entries are words, counted downward from the top of the table
    assign scaled = DATA_W'(num) << 2;

    always_comb begin
        if (is_emu) begin
            vec_addr = tbr + DATA_W'(EMU_OFF);
        end else begin
            vec_addr = tbr + DATA_W'(VEC_TOP) - scaled;
        end
    end
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
    import trap_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_op_t    start_op,
    input  logic       mem_ready,
    output seq_state_t state
);
    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_op == OP_TRAP || start_op == OP_EMU) begin
                    state_nx = ST_PUSH_PS;
                end else if (start_op == OP_RET) begin
                    state_nx = ST_POP_PC;
                end
            end
            ST_PUSH_PS: if (mem_ready) state_nx = ST_PUSH_PC;
            ST_PUSH_PC: if (mem_ready) state_nx = ST_VEC_RD;
            ST_VEC_RD:  if (mem_ready) state_nx = ST_COMMIT;
            ST_POP_PC:  if (mem_ready) state_nx = ST_POP_PS;
            ST_POP_PS:  if (mem_ready) state_nx = ST_COMMIT;
            ST_COMMIT:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_W   = 8,
    parameter int VEC_TOP = 'h3FC,
    parameter int EMU_OFF = 'h3D8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_trap,
    input  logic              req_emu,
    input  logic              req_ret,
    input  logic [NUM_W-1:0]  trap_num,
    input  logic [DATA_W-1:0] arch_pc,
    input  logic [DATA_W-1:0] arch_ps,
    input  logic [DATA_W-1:0] arch_ssp,
    input  logic [DATA_W-1:0] arch_gsp,
    input  logic [DATA_W-1:0] arch_tbr,
    output logic              busy,
    output logic              commit,
    output logic [DATA_W-1:0] new_pc,
    output logic [DATA_W-1:0] new_ps,
    output logic [DATA_W-1:0] new_ssp,
    output logic [DATA_W-1:0] new_gsp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam logic [DATA_W-1:0] WORD    = DATA_W'(4);
    localparam logic [DATA_W-1:0] TWO_WD  = DATA_W'(8);
    localparam logic [DATA_W-1:0] INSN_SZ = DATA_W'(2);
    localparam logic [DATA_W-1:0] MASK_S  = DATA_W'(1) << PS_BIT_S;
    localparam logic [DATA_W-1:0] MASK_IS = MASK_S | (DATA_W'(1) << PS_BIT_I);

    seq_state_t state;
    seq_op_t    sel_op;
    seq_op_t    op_q;

    logic [DATA_W-1:0] pc_q, ps_q, ssp_q, gsp_q, tbr_q;
    logic [NUM_W-1:0]  num_q;
    logic [DATA_W-1:0] vec_addr;
    logic [DATA_W-1:0] res_pc, res_ps, res_ssp, res_gsp;

    // fixed priority among simultaneous requests
    always_comb begin
        if (req_trap)      sel_op = OP_TRAP;
        else if (req_emu)  sel_op = OP_EMU;
        else if (req_ret)  sel_op = OP_RET;
        else               sel_op = OP_NONE;
    end

    trap_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_op  ((state == ST_IDLE) ? sel_op : OP_NONE),
        .mem_ready (mem_ready),
        .state     (state)
    );

    trap_seq_vec #(
        .DATA_W  (DATA_W),
        .NUM_W   (NUM_W),
        .VEC_TOP (VEC_TOP),
        .EMU_OFF (EMU_OFF)
    ) u_vec (
        .tbr      (tbr_q),
        .num      (num_q),
        .is_emu   (op_q == OP_EMU),
        .vec_addr (vec_addr)
    );

    // capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            pc_q    <= '0;
            ps_q    <= '0;
            ssp_q   <= '0;
            gsp_q   <= '0;
            tbr_q   <= '0;
            num_q   <= '0;
            res_pc  <= '0;
            res_ps  <= '0;
            res_ssp <= '0;
            res_gsp <= '0;
        end else begin
            if (state == ST_IDLE && sel_op != OP_NONE) begin
                op_q  <= sel_op;
                pc_q  <= arch_pc;
                ps_q  <= arch_ps;
                ssp_q <= arch_ssp;
                gsp_q <= arch_gsp;
                tbr_q <= arch_tbr;
                num_q <= trap_num;
            end
            if (mem_ready) begin
                unique case (state)
                    ST_VEC_RD: begin
                        res_pc  <= mem_rdata;
                        res_ps  <= ps_q & ~((op_q == OP_EMU) ? MASK_S : MASK_IS);
                        res_ssp <= ssp_q - TWO_WD;
                        res_gsp <= gsp_q;
                    end
                    ST_POP_PC: begin
                        res_pc <= mem_rdata;
                    end
                    ST_POP_PS: begin
                        res_ps  <= mem_rdata;
                        res_ssp <= ssp_q;
                        res_gsp <= gsp_q + TWO_WD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_PS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ssp_q - WORD;
                mem_wdata = ps_q;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ssp_q - TWO_WD;
                mem_wdata = pc_q + INSN_SZ;
            end
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = gsp_q;
            end
            ST_POP_PS: begin
                mem_req  = 1'b1;
                mem_addr = gsp_q + WORD;
            end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign commit  = (state == ST_COMMIT);
    assign new_pc  = res_pc;
    assign new_ps  = res_ps;
    assign new_ssp = res_ssp;
    assign new_gsp = res_gsp;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
    import trap_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              commit,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] new_ps,
    input logic [DATA_W-1:0] ps_q,
    input seq_op_t           op_q
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !commit));

    assert_hold_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

    assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!commit && !busy));

    assert_trap_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_TRAP) |-> (!new_ps[PS_BIT_I] && !new_ps[PS_BIT_S]));

    assert_emu_keeps_i_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_EMU) |-> (!new_ps[PS_BIT_S] && new_ps[PS_BIT_I] == ps_q[PS_BIT_I]));

    assert_ret_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && op_q == OP_RET) |-> !mem_we);

endmodule

bind trap_seq trap_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .commit    (commit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .new_ps    (new_ps),
    .ps_q      (ps_q),
    .op_q      (op_q)
);

// File: tb/tb_trap_seq.sv
module tb_trap_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } txn_t;

    typedef struct {
        logic [31:0] pc, ps, ssp, gsp;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_trap = 1'b0, req_emu = 1'b0, req_ret = 1'b0;
    logic [7:0]  trap_num = '0;
    logic [31:0] arch_pc = '0, arch_ps = '0, arch_ssp = '0, arch_gsp = '0, arch_tbr = '0;
    logic        busy, commit, mem_req, mem_we;
    logic [31:0] new_pc, new_ps, new_ssp, new_gsp, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int wait_cyc = 0;
    int wcnt = 0;

    logic [31:0] mem [logic [31:0]];
    txn_t        txq[$];
    res_t        resq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_trap(req_trap), .req_emu(req_emu), .req_ret(req_ret),
        .trap_num(trap_num),
        .arch_pc(arch_pc), .arch_ps(arch_ps), .arch_ssp(arch_ssp),
        .arch_gsp(arch_gsp), .arch_tbr(arch_tbr),
        .busy(busy), .commit(commit),
        .new_pc(new_pc), .new_ps(new_ps), .new_ssp(new_ssp), .new_gsp(new_gsp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural memory with a programmable number of wait cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
        if (!mem_req) begin
            wcnt = 0;
        end else if (wcnt >= wait_cyc) begin
            mem_ready = 1'b1;
            mem_rdata = rd(mem_addr);
            if (mem_we) mem[mem_addr] = mem_wdata;
        end else begin
            wcnt++;
        end
    end

    // monitor: compares handshakes and commits against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_req && mem_ready) begin
            if (txq.size() == 0) begin
                check(1'b0, "R8 unexpected access", mem_addr, 32'h0);
            end else begin
                txn_t t;
                t = txq.pop_front();
                check(mem_we == t.we, "R2/R6 access direction", {31'h0, mem_we}, {31'h0, t.we});
                check(mem_addr == t.addr, "R2/R3/R5/R6 access address", mem_addr, t.addr);
                if (t.we) check(mem_wdata == t.data, "R2 write data", mem_wdata, t.data);
            end
        end
        if (rst_n && commit) begin
            if (resq.size() == 0) begin
                check(1'b0, "R8 unexpected commit", new_pc, 32'h0);
            end else begin
                res_t r;
                r = resq.pop_front();
                check(new_pc == r.pc, "R3/R5/R6 new_pc", new_pc, r.pc);
                check(new_ps == r.ps, "R4/R5/R6 new_ps", new_ps, r.ps);
                check(new_ssp == r.ssp, "R4/R6 new_ssp", new_ssp, r.ssp);
                check(new_gsp == r.gsp, "R4/R6 new_gsp", new_gsp, r.gsp);
            end
        end
    end

    // driver: queues expected traffic and results, then runs the request
    task automatic run_op(input bit t, input bit e, input bit r, input logic [7:0] n,
                          input int w, input bit poke);
        res_t ex;
        int   kind;
        int   cyc;
        int   exp_cyc;
        wait_cyc = w;
        kind = t ? 1 : (e ? 2 : 3);
        ex.pc = arch_pc; ex.ps = arch_ps; ex.ssp = arch_ssp; ex.gsp = arch_gsp;
        if (kind != 3) begin
            logic [31:0] va;
            va = (kind == 2) ? arch_tbr + 32'h3D8 : arch_tbr + 32'h3FC - {22'h0, n, 2'b00};
            txq.push_back('{1'b1, arch_ssp - 32'd4, arch_ps});
            txq.push_back('{1'b1, arch_ssp - 32'd8, arch_pc + 32'd2});
            txq.push_back('{1'b0, va, 32'h0});
            ex.pc  = rd(va);
            ex.ps  = arch_ps & ~((kind == 2) ? 32'h20 : 32'h30);
            ex.ssp = arch_ssp - 32'd8;
            exp_cyc = 3 * (w + 1) + 1;
        end else begin
            txq.push_back('{1'b0, arch_gsp, 32'h0});
            txq.push_back('{1'b0, arch_gsp + 32'd4, 32'h0});
            ex.pc  = rd(arch_gsp);
            ex.ps  = rd(arch_gsp + 32'd4);
            ex.gsp = arch_gsp + 32'd8;
            exp_cyc = 2 * (w + 1) + 1;
        end
        resq.push_back(ex);
        trap_num = n;
        req_trap = t; req_emu = e; req_ret = r;
        cyc = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            req_trap = 1'b0; req_emu = 1'b0; req_ret = 1'b0;
            if (poke && cyc == 2) req_ret = 1'b1;
            if (!busy) break;
            cyc++;
        end
        req_ret = 1'b0;
        check(cyc == exp_cyc, "R7 busy length", cyc, exp_cyc);
        arch_pc = ex.pc; arch_ps = ex.ps; arch_ssp = ex.ssp; arch_gsp = ex.gsp;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pre_pc, pre_ps, pre_ssp;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(!busy, "R1 busy after reset", {31'h0, busy}, 32'h0);
        check(!commit, "R1 commit after reset", {31'h0, commit}, 32'h0);
        check(!mem_req, "R1 mem_req after reset", {31'h0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: numbered trap, all flags set, no waits
        arch_tbr = 32'h0001_0000; arch_pc = 32'h1000; arch_ps = 32'h3F;
        arch_ssp = 32'h8000; arch_gsp = 32'h4000;
        mem[32'h0001_03E8] = 32'h2000;
        run_op(1, 0, 0, 8'd5, 0, 0);

        // R3: table top (n=0) and bottom (n=255) with wait cycles (R7)
        mem[32'h0001_03FC] = 32'h3000;
        mem[32'h0001_0000] = 32'h3100;
        arch_ps = 32'h1A;
        run_op(1, 0, 0, 8'd0, 2, 0);
        arch_ps = 32'h25;
        run_op(1, 0, 0, 8'd255, 1, 0);

        // R5: emulator trap keeps I
        mem[32'h0001_03D8] = 32'h5000;
        arch_ps = 32'h39;
        run_op(0, 1, 0, 8'd7, 0, 0);

        // R6: return with a prepared frame, flags 0101 in NZVC
        arch_gsp = 32'h6000;
        mem[32'h6000] = 32'h0000_7770;
        mem[32'h6004] = 32'h0000_0015;
        run_op(0, 0, 1, 8'd0, 1, 0);

        // R9: priority among simultaneous requests
        mem[32'h0001_03F8] = 32'h3200;
        arch_ps = 32'h30;
        run_op(1, 1, 1, 8'd1, 0, 0);
        run_op(0, 1, 1, 8'd1, 0, 0);

        // R8: return request during a trap is ignored
        arch_ps = 32'h10;
        run_op(1, 0, 0, 8'd5, 0, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!mem_req && !busy, "R8 ignored request started work",
                  {30'h0, mem_req, busy}, 32'h0);
        end

        // R10: round trip restores state
        arch_pc = 32'h0000_0A00; arch_ps = 32'h1C; arch_ssp = 32'h9000;
        pre_pc = arch_pc; pre_ps = arch_ps; pre_ssp = arch_ssp;
        run_op(1, 0, 0, 8'd5, 1, 0);
        arch_ps = arch_ps & ~32'h20;
        arch_gsp = arch_ssp;
        run_op(0, 0, 1, 8'd0, 0, 0);
        check(arch_pc == pre_pc + 32'd2, "R10 round-trip PC", arch_pc, pre_pc + 32'd2);
        check(arch_ps == pre_ps, "R10 round-trip PS", arch_ps, pre_ps);
        check(arch_gsp == pre_ssp, "R10 round-trip stack pointer", arch_gsp, pre_ssp);

        repeat (2) @(negedge clk);
        check(txq.size() == 0 && resq.size() == 0, "R2 scoreboard drained",
              txq.size() + resq.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule